// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Protocol Engine

This block is the bus-facing front end of a 16K x 8 non-volatile memory. It watches a two-wire serial bus (clock and data lines) with a fast system clock, recognises Start and Stop conditions, shifts bytes in and out, and drives the data line through an open-drain pull-down enable. It decodes the device control byte against three strap inputs, loads a 14-bit word address from two address bytes, and keeps an internal address pointer that survives from one transaction to the next.

Write data bytes are handed one at a time to a separate page-buffer block, together with the address each byte belongs to. On the Stop that ends a write, the engine raises a commit pulse. While the page buffer reports that its internal write cycle is busy, the engine acknowledges nothing, so a bus master can poll for completion. Read data comes from a combinational array read port addressed by the pointer. The engine supports byte and multi-byte writes, current-address reads, random reads and sequential reads.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A Start (data falling while the clock is high) in any state abandons the current transfer, releases the data line and begins reception of a control byte. A Stop (data rising while the clock is high) returns the engine to idle with the data line released. An abandoned partial address never changes the pointer.
- R2: The control byte is the first byte after a Start, sent MSB first. Bits [7:4] must be 4'b1010 and bits [3:1] must equal `strap_i[2:0]`. Bit 0 selects read (1) or write (0). On a match the engine pulls the data line low for the acknowledge clock. On a mismatch it never drives the line until the next Start.
- R3: While `wr_busy_i` is high, no byte is acknowledged, including a matching control byte.
- R4: After a write control byte, the next two bytes are the address high byte and then the low byte. The pointer becomes {high[5:0], low[7:0]}, and high bits [7:6] are ignored.
- R5: Each write data byte is acknowledged and presented for exactly one cycle on `wr_valid_o`, with `wr_data_o` and with `wr_addr_o` set to the pointer value at the time of that byte.
- R6: During a write, the pointer advances only in its low 6 bits, so data wraps to the start of the same 64-byte page.
- R7: `wr_commit_o` pulses for one cycle on a Stop that ends a write carrying at least one data byte. A Stop after a control byte alone, after address bytes alone, or after a read gives no pulse.
- R8: In a random read, a repeated Start after the two address bytes keeps the new pointer, and a read control byte then returns the byte at that address, MSB first.
- R9: After a read byte, a master ACK (data low on the ninth clock) makes the engine send the next byte. A NACK makes it release the line and stay off the bus until Start or Stop.
- R10: The pointer advances by one after each byte read and wraps from 0x3FFF to 0x0000. A current-address read returns the byte at the last accessed address plus one, and `rd_addr_o` always shows the pointer.
- R11: `sda_oe_o` changes only in the cycle after a detected clock falling edge, Start or Stop, and never while the bus clock is high.
- R12: After reset, `sda_oe_o`, `wr_valid_o` and `wr_commit_o` are 0 and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| strap_i | input | 3 | Device select strap levels |
| wr_busy_i | input | 1 | Page buffer internal write cycle in progress |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | 14 | Address of the write byte |
| wr_data_o | output | 8 | Write byte value |
| wr_commit_o | output | 1 | One-cycle pulse: Stop ended a write with data |
| rd_addr_o | output | 14 | Current pointer, array read address |
| rd_data_i | input | 8 | Array data at `rd_addr_o` |

## Verification
The bench targets a sequential read across 0x3FFF. A design that wraps the pointer wrongly, or that increments it at the wrong moment, returns the wrong second or third byte. A three-byte write starting two bytes before a page end must place its third byte at the page start. A full 14-bit increment would show up as an address in the next page, and a missing commit, or a commit after a pure address write, shows as a wrong pulse count. Busy polling, a wrong device code or strap, and a Start in the middle of an address byte are each probed at the data line. An engine that acknowledges under busy, that answers a foreign device, or that loads a half-received address gives a visible wrong ACK or wrong read data.

// File: rtl/eis_pkg.sv
package eis_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_ADDR_HI,
    S_ADDR_LO,
    S_WDATA,
    S_RDATA,
    S_SKIP
  } eis_state_e;

  // bit counter values: 0..7 data bits, 8 = byte done, 9 = ack slot
  localparam logic [3:0] BC_DONE = 4'd8;
  localparam logic [3:0] BC_ACK  = 4'd9;
endpackage

// File: rtl/eis_bus_cond.sv
module eis_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, lvl, lvl_q;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '1;
      else         ff <= {ff[SYNC_STAGES-2:0], raw[g]};
    end
    assign lvl[g] = ff[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '1;
    else         lvl_q <= lvl;
  end

  logic scl_s, sda_s, scl_q, sda_q;
  assign {scl_s, sda_s} = lvl;
  assign {scl_q, sda_q} = lvl_q;

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eis_addr_ptr.sv
module eis_addr_ptr #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic              page_wrap_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_inc;

  always_comb begin
    if (page_wrap_i)
      ptr_inc = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
    else
      ptr_inc = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_i)  ptr_q <= ptr_inc;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/eis_proto_fsm.sv
module eis_proto_fsm
  import eis_pkg::*;
#(
  parameter int         ADDR_W   = 14,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              ptr_load_o,
  output logic [ADDR_W-1:0] ptr_load_val_o,
  output logic              ptr_inc_o,
  output logic              ptr_wrap_o
);
  localparam int HI_W = ADDR_W - 8;

  eis_state_e        state_q, nxt_q;
  logic [3:0]        bc_q;
  logic [7:0]        sh_q;
  logic              oe_q, mack_q, seen_q;
  logic [HI_W-1:0]   hi_q;
  logic              wv_q, cm_q, ld_q, inc_q, wrap_q;
  logic [ADDR_W-1:0] wa_q, ldv_q;
  logic [7:0]        wd_q;
  logic              ack_ok;

  always_comb begin
    ack_ok = !busy_i;
    if (state_q == S_CTRL)
      ack_ok = ack_ok && (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == strap_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      nxt_q   <= S_IDLE;
      bc_q    <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
      seen_q  <= 1'b0;
      hi_q    <= '0;
      wv_q    <= 1'b0;
      cm_q    <= 1'b0;
      ld_q    <= 1'b0;
      inc_q   <= 1'b0;
      wrap_q  <= 1'b0;
      wa_q    <= '0;
      ldv_q   <= '0;
      wd_q    <= '0;
    end else begin
      wv_q  <= 1'b0;
      cm_q  <= 1'b0;
      ld_q  <= 1'b0;
      inc_q <= 1'b0;
      if (start_i) begin
        state_q <= S_CTRL;
        bc_q    <= '0;
        oe_q    <= 1'b0;
        seen_q  <= 1'b0;
      end else if (stop_i) begin
        if (state_q == S_WDATA && seen_q) cm_q <= 1'b1;
        state_q <= S_IDLE;
        bc_q    <= '0;
        oe_q    <= 1'b0;
        seen_q  <= 1'b0;
      end else begin
        unique case (state_q)
          S_IDLE, S_SKIP: ;
          S_RDATA: begin
            if (scl_rise_i) begin
              if (bc_q < BC_DONE)     bc_q <= bc_q + 4'd1;
              else if (bc_q == BC_ACK) mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (bc_q == BC_DONE) begin
                oe_q   <= 1'b0;
                bc_q   <= BC_ACK;
                inc_q  <= 1'b1;
                wrap_q <= 1'b0;
              end else if (bc_q == BC_ACK) begin
                if (mack_q) begin
                  sh_q <= rd_data_i;
                  oe_q <= ~rd_data_i[7];
                  bc_q <= '0;
                end else begin
                  state_q <= S_SKIP;
                  oe_q    <= 1'b0;
                end
              end else if (bc_q != 4'd0) begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          default: begin
            if (scl_rise_i && bc_q < BC_DONE) begin
              sh_q <= {sh_q[6:0], sda_i};
              bc_q <= bc_q + 4'd1;
            end else if (scl_fall_i && bc_q == BC_DONE) begin
              if (ack_ok) begin
                oe_q <= 1'b1;
                bc_q <= BC_ACK;
                unique case (state_q)
                  S_CTRL:    nxt_q <= sh_q[0] ? S_RDATA : S_ADDR_HI;
                  S_ADDR_HI: begin
                    hi_q  <= sh_q[HI_W-1:0];
                    nxt_q <= S_ADDR_LO;
                  end
                  S_ADDR_LO: begin
                    ld_q  <= 1'b1;
                    ldv_q <= {hi_q, sh_q};
                    nxt_q <= S_WDATA;
                  end
                  default: begin
                    wv_q   <= 1'b1;
                    wa_q   <= ptr_i;
                    wd_q   <= sh_q;
                    inc_q  <= 1'b1;
                    wrap_q <= 1'b1;
                    seen_q <= 1'b1;
                    nxt_q  <= S_WDATA;
                  end
                endcase
              end else begin
                state_q <= S_SKIP;
              end
            end else if (scl_fall_i && bc_q == BC_ACK) begin
              bc_q    <= '0;
              state_q <= nxt_q;
              if (nxt_q == S_RDATA) begin
                sh_q <= rd_data_i;
                oe_q <= ~rd_data_i[7];
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
        endcase
      end
    end
  end

  assign sda_oe_o       = oe_q;
  assign wr_valid_o     = wv_q;
  assign wr_addr_o      = wa_q;
  assign wr_data_o      = wd_q;
  assign wr_commit_o    = cm_q;
  assign ptr_load_o     = ld_q;
  assign ptr_load_val_o = ldv_q;
  assign ptr_inc_o      = inc_q;
  assign ptr_wrap_o     = wrap_q;
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eis_pkg::*;
#(
  parameter int         ADDR_W      = 14,
  parameter int         PAGE_W      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              wr_busy_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, ptr_inc, ptr_wrap;
  logic [ADDR_W-1:0] ptr, ptr_load_val;

  eis_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_bus_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  eis_proto_fsm #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sda_i          (sda_s),
    .scl_rise_i     (scl_rise),
    .scl_fall_i     (scl_fall),
    .start_i        (start_det),
    .stop_i         (stop_det),
    .strap_i        (strap_i),
    .busy_i         (wr_busy_i),
    .rd_data_i      (rd_data_i),
    .ptr_i          (ptr),
    .sda_oe_o       (sda_oe_o),
    .wr_valid_o     (wr_valid_o),
    .wr_addr_o      (wr_addr_o),
    .wr_data_o      (wr_data_o),
    .wr_commit_o    (wr_commit_o),
    .ptr_load_o     (ptr_load),
    .ptr_load_val_o (ptr_load_val),
    .ptr_inc_o      (ptr_inc),
    .ptr_wrap_o     (ptr_wrap)
  );

  eis_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ptr_load),
    .load_val_i  (ptr_load_val),
    .inc_i       (ptr_inc),
    .page_wrap_i (ptr_wrap),
    .ptr_o       (ptr)
  );

  assign rd_addr_o = ptr;
endmodule

// File: rtl/eis_checker.sv
module eis_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_busy_i,
  input logic sda_oe_o,
  input logic wr_valid_o,
  input logic wr_commit_o,
  input logic scl_fall_i,
  input logic start_i,
  input logic stop_i
);
  // R11: output moves only after a clock fall or a bus condition
  assert_oe_on_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i));

  // R3: no pull-down starts while the page buffer was busy
  assert_busy_no_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(wr_busy_i));

  // R5: write strobe is a single-cycle pulse
  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  // R7: commit follows a Stop and lasts one cycle
  assert_commit_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(stop_i));
  assert_commit_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o);

  // R1: line released after a Stop
  assert_stop_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> !sda_oe_o);
endmodule

bind eeprom_i2c_slave eis_checker u_eis_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_busy_i   (wr_busy_i),
  .sda_oe_o    (sda_oe_o),
  .wr_valid_o  (wr_valid_o),
  .wr_commit_o (wr_commit_o),
  .scl_fall_i  (scl_fall),
  .start_i     (start_det),
  .stop_i      (stop_det)
);

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int Q = 8;
  localparam logic [7:0] CW = 8'hAA;  // 1010_101_0
  localparam logic [7:0] CR = 8'hAB;  // 1010_101_1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, wr_valid, wr_commit;
  logic [13:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_oe;

  function automatic logic [7:0] patt(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction
  assign rd_data = patt(rd_addr);

  eeprom_i2c_slave i_eeprom_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .wr_busy_i(busy),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  int checks = 0, errors = 0, commits = 0, cap_n = 0, oe_bad = 0;
  logic [13:0] cap_a [16];
  logic [7:0]  cap_d [16];
  logic oe_prev = 1'b0;
  bit done = 0;

  always @(negedge clk) begin
    if (wr_valid && cap_n < 16) begin
      cap_a[cap_n] = wr_addr;
      cap_d[cap_n] = wr_data;
      cap_n++;
    end
    if (wr_commit) commits++;
    if (sda_oe !== oe_prev && m_scl) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    wq(Q);
    m_scl = 1'b1; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q / 2);
    ack = ~sda_bus;
    wq(Q / 2);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      m_scl = 1'b1; wq(Q / 2);
      b[i] = sda_bus;
      wq(Q / 2);
      m_scl = 1'b0;
    end
    m_sda = ~mack; wq(Q);
    m_scl = 1'b1;  wq(Q);
    m_scl = 1'b0;  m_sda = 1'b1;
  endtask

  task automatic t_reset();
    check("R12 oe after reset", sda_oe, 0);
    check("R12 wr_valid after reset", wr_valid, 0);
    check("R12 commit after reset", wr_commit, 0);
    check("R12 pointer after reset", rd_addr, 14'h0000);
  endtask

  task automatic t_bad_ctrl();
    logic a;
    bus_start(); send_byte(8'hBA, a);  // wrong code
    check("R2 wrong code nack", a, 0);
    send_byte(8'h00, a);
    check("R2 stays off bus after mismatch", a, 0);
    bus_stop();
    bus_start(); send_byte(8'hA6, a);  // strap 011
    check("R2 wrong strap nack", a, 0);
    bus_stop();
  endtask

  task automatic t_byte_write();
    logic a;
    int n0 = cap_n, c0 = commits;
    bus_start();
    send_byte(CW, a);    check("R2 matching control ack", a, 1);
    send_byte(8'hC1, a); check("R4 address high ack", a, 1);
    send_byte(8'h23, a); check("R4 address low ack", a, 1);
    send_byte(8'h77, a); check("R5 data ack", a, 1);
    bus_stop();
    check("R5 one strobe", cap_n - n0, 1);
    check("R4 addr high bits ignored", cap_a[n0], 14'h0123);
    check("R5 write data", cap_d[n0], 8'h77);
    check("R7 commit after write", commits - c0, 1);
    check("R10 pointer after write", rd_addr, 14'h0124);
  endtask

  task automatic t_busy_poll();
    logic a;
    int c0 = commits;
    busy = 1'b1;
    bus_start(); send_byte(CW, a);
    check("R3 no ack while busy", a, 0);
    bus_stop();
    busy = 1'b0;
    bus_start(); send_byte(CW, a);
    check("R3 ack after busy ends", a, 1);
    bus_stop();
    check("R7 no commit for control only", commits - c0, 0);
  endtask

  task automatic t_page_wrap();
    logic a;
    int n0 = cap_n, c0 = commits;
    bus_start();
    send_byte(CW, a); send_byte(8'h01, a); send_byte(8'h3E, a);
    send_byte(8'hA1, a); send_byte(8'hA2, a); send_byte(8'hA3, a);
    check("R6 third byte ack", a, 1);
    bus_stop();
    check("R6 strobe count", cap_n - n0, 3);
    check("R6 first addr", cap_a[n0], 14'h013E);
    check("R6 second addr", cap_a[n0 + 1], 14'h013F);
    check("R6 wraps to page start", cap_a[n0 + 2], 14'h0100);
    check("R6 third data", cap_d[n0 + 2], 8'hA3);
    check("R7 commit after page write", commits - c0, 1);
  endtask

  task automatic t_random_seq_read();
    logic a;
    logic [7:0] d;
    int c0 = commits;
    bus_start();
    send_byte(CW, a); send_byte(8'h3F, a); send_byte(8'hFE, a);
    bus_start();
    send_byte(CR, a); check("R8 read control ack", a, 1);
    recv_byte(1'b1, d); check("R8 random read data", d, patt(14'h3FFE));
    recv_byte(1'b1, d); check("R9 ack gives next byte", d, patt(14'h3FFF));
    recv_byte(1'b0, d); check("R10 wrap to 0000", d, patt(14'h0000));
    recv_byte(1'b0, d); check("R9 released after nack", d, 8'hFF);
    bus_stop();
    check("R10 pointer after wrap", rd_addr, 14'h0001);
    check("R7 no commit for read", commits - c0, 0);
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(CR, a);
    recv_byte(1'b0, d);
    bus_stop();
    check("R10 current address read", d, patt(14'h0001));
  endtask

  task automatic t_start_abort();
    logic a;
    logic [7:0] d;
    int c0 = commits;
    bus_start();
    send_byte(CW, a); send_byte(8'h12, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(CR, a); check("R1 ack after abort start", a, 1);
    recv_byte(1'b0, d); check("R1 partial address not loaded", d, patt(14'h0002));
    bus_stop();
    wq(2);
    check("R1 released after stop", sda_oe, 0);
    check("R7 no commit for aborted write", commits - c0, 0);
  endtask

  initial begin
    wq(3);
    t_reset();
    rst_n = 1'b1;
    wq(5);
    t_bad_ctrl();
    t_byte_write();
    t_busy_poll();
    t_page_wrap();
    t_random_seq_read();
    t_current_read();
    t_start_abort();
    check("R11 oe never moves with clock high", oe_bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wq(150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule